// File: doc/BRIEF.md
# Stop-Mode Wake and Clock Handover Controller

This controller puts a small microcontroller core into its deepest sleep state and brings it back out. Software arms a stop request through a small register port. Once the instruction that armed it reports completion, the controller shuts off the core clock, both clock-source selects and the crystal-oscillator enable. While the core sleeps, only wake events of an allowed class can end the sleep. An enabled external interrupt always qualifies. An enabled power-fail interrupt and the power-fail reset qualify only if software chose to keep the bandgap reference alive through stop. The internal timer, serial and watchdog interrupts never qualify.

After a wake the core can restart in one of two ways. In the first, it waits with its clock off until the crystal has run for a fixed number of its own cycles. In the second, it resumes at once from a fast-starting internal ring clock and is moved to the crystal once that same count completes. The count runs in the crystal's clock domain. Its completion crosses into the controller's always-on clock through two-flop synchronizers. The controller swaps clock sources without overlap: it passes through one cycle in which neither select is active. A power-fail reset wake returns the control bits to their defaults and always takes the crystal path.

The port carries no data stream, only plain control and status pins. A register write takes effect on the clock edge where `reg_we` is high. A read is combinational from `reg_addr`.

Top module: `stopwake_ctrl`

## Requirements
- R1: Register map, all fields reset to 0 and unlisted bits reading 0. Address 0 holds the stop request at bit 1 (read/write). Address 1 holds the bandgap-keep bit at bit 0. Address 2 holds the ring-select bit at bit 1 and the read-only ring-active status at bit 2. Address 3 reads 0.
- R2: A set stop request enters stop on the edge where `instr_done` is high, and no earlier. `stopped` rises in the following cycle and the stop bit reads 0 from then on.
- R3: While `stopped` is high, `xtal_en`, `core_clk_en`, `sel_ring` and `sel_xtal` are all 0.
- R4: In stop, `ext_irq` wakes the core when `ext_irq_en` is 1 and is ignored when it is 0.
- R5: The internal interrupts `int_irq` (timer, serial, watchdog) never end stop.
- R6: With bandgap-keep at 1, `bandgap_en` stays 1 in stop, and both an enabled `pf_irq` and `pf_rst` wake the core. With bandgap-keep at 0, `bandgap_en` is 0 in stop and both power-fail events are ignored.
- R7: Outside stop, `bandgap_en` is 1 whatever the bandgap-keep bit holds.
- R8: With ring-select at 0, a wake raises `xtal_en` but keeps `core_clk_en` and `sel_ring` low. `sel_xtal` rises only after `SETTLE_CYCLES` crystal cycles plus the synchronizer latency.
- R9: With ring-select at 1, an interrupt wake raises `sel_ring` and `core_clk_en` in the next cycle, and ring-active reads 1.
- R10: The ring phase ends only after `SETTLE_CYCLES` crystal cycles. Ring-active clears together with `sel_ring`, one cycle passes with both selects low, and then `sel_xtal` rises.
- R11: A power-fail reset wake clears the bandgap-keep and ring-select bits and restarts on the crystal path.
- R12: A stop-request write made while the ring phase is active is ignored. After the handover the stop bit reads 0, and `instr_done` does not enter stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_clk | input | 1 | Crystal oscillator clock, used for the settle count |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2 | Write data (bits 1..0) |
| reg_rdata | output | 3 | Combinational read data |
| instr_done | input | 1 | The current core instruction completes this cycle |
| ext_irq | input | 1 | External interrupt request |
| ext_irq_en | input | 1 | External interrupt enable |
| pf_irq | input | 1 | Power-fail interrupt from the comparator |
| pf_irq_en | input | 1 | Power-fail interrupt enable |
| pf_rst | input | 1 | Power-fail reset from the comparator |
| int_irq | input | 3 | Timer, serial and watchdog interrupt requests |
| stopped | output | 1 | The core is in stop mode |
| core_clk_en | output | 1 | Core clock gate enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| bandgap_en | output | 1 | Bandgap reference enable |
| sel_ring | output | 1 | Core clock taken from the ring oscillator |
| sel_xtal | output | 1 | Core clock taken from the crystal |

## Verification
The assertions assume that `xtal_clk` toggles whenever `xtal_en` is high and that `rst_n` resets both clock domains together. They also assume that wake inputs are sampled as levels on `clk` and that `instr_done` refers to the instruction that wrote the stop bit. The stimulus keeps to these assumptions. It runs the crystal freely at an unrelated period and drives every input one nanosecond after a `clk` edge. It waits for the completion handshake to drain before arming stop again. The sweep covers every combination of bandgap-keep, ring-select and wake source against a short settle count. The bench bounds the settle time arithmetically from the two clock periods.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOP,
    ST_SETTLE,
    ST_RING,
    ST_HANDOFF
  } sw_state_e;

  localparam logic [1:0] ADDR_PWR = 2'd0;
  localparam logic [1:0] ADDR_RST = 2'd1;
  localparam logic [1:0] ADDR_EXT = 2'd2;
  localparam int BIT_STOP = 1;
  localparam int BIT_BGS  = 0;
  localparam int BIT_RSEL = 1;
  localparam int BIT_RACT = 2;
  localparam int RD_W     = 3;
  localparam int WR_W     = 2;
endpackage

// File: rtl/sw_sync2.sv
module sw_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sw_settle.sv
module sw_settle #(
  parameter int SETTLE_CYCLES = 65536
) (
  input  logic xtal_clk,
  input  logic rst_n,
  input  logic req,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic          req_x;
  logic [CW-1:0] cnt;

  sw_sync2 u_req_sync (.clk(xtal_clk), .rst_n(rst_n), .d(req), .q(req_x));

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!req_x) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) done <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  a_r10_done_needs_request: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    $rose(done) |-> $past(req_x));
endmodule

// File: rtl/sw_regs.sv
module sw_regs
  import stopwake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [WR_W-1:0]  wdata,
  output logic [RD_W-1:0]  rdata,
  input  logic             in_run,
  input  logic             stop_take,
  input  logic             soft_clr,
  input  logic             ring_mode,
  output logic             stop_pend,
  output logic             bgs,
  output logic             rsel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_pend <= 1'b0;
      bgs       <= 1'b0;
      rsel      <= 1'b0;
    end else if (soft_clr) begin
      stop_pend <= 1'b0;
      bgs       <= 1'b0;
      rsel      <= 1'b0;
    end else begin
      if (stop_take)
        stop_pend <= 1'b0;
      else if (we && addr == ADDR_PWR && in_run)
        stop_pend <= wdata[BIT_STOP];
      if (we && addr == ADDR_RST) bgs  <= wdata[BIT_BGS];
      if (we && addr == ADDR_EXT) rsel <= wdata[BIT_RSEL];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_PWR: rdata[BIT_STOP] = stop_pend;
      ADDR_RST: rdata[BIT_BGS]  = bgs;
      ADDR_EXT: begin
        rdata[BIT_RSEL] = rsel;
        rdata[BIT_RACT] = ring_mode;
      end
      default:  rdata = '0;
    endcase
  end

  a_r12_stop_write_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_PWR && !in_run) |=> !stop_pend);
endmodule

// File: rtl/sw_fsm.sv
module sw_fsm
  import stopwake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_pend,
  input  logic instr_done,
  input  logic settle_done,
  input  logic wake_irq,
  input  logic wake_rst,
  input  logic ring_sel,
  output logic stopped,
  output logic core_clk_en,
  output logic xtal_en,
  output logic sel_ring,
  output logic sel_xtal,
  output logic ring_mode,
  output logic in_run,
  output logic stop_take,
  output logic soft_clr,
  output logic settle_req
);
  sw_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:     if (stop_pend && instr_done && !settle_done) nxt = ST_STOP;
      ST_STOP: begin
        if (wake_rst)      nxt = ST_SETTLE;
        else if (wake_irq) nxt = ring_sel ? ST_RING : ST_SETTLE;
      end
      ST_SETTLE:  if (settle_done) nxt = ST_RUN;
      ST_RING:    if (settle_done) nxt = ST_HANDOFF;
      ST_HANDOFF: nxt = ST_RUN;
      default:    nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign stopped     = (state == ST_STOP);
  assign in_run      = (state == ST_RUN);
  assign ring_mode   = (state == ST_RING);
  assign sel_ring    = (state == ST_RING);
  assign sel_xtal    = (state == ST_RUN);
  assign core_clk_en = (state == ST_RUN) || (state == ST_RING);
  assign xtal_en     = (state != ST_STOP);
  assign settle_req  = (state == ST_SETTLE) || (state == ST_RING);
  assign stop_take   = in_run && (nxt == ST_STOP);
  assign soft_clr    = stopped && wake_rst;

  // R2: stop entered only on a completed instruction with the request armed
  a_r2_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> $past(instr_done && stop_pend));
  // R9: ring clock runs the core right after an interrupt wake
  a_r9_ring_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && wake_irq && !wake_rst && ring_sel) |=> (sel_ring && core_clk_en));
  // R8: no ring phase when ring-select is clear
  a_r8_crystal_path: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !ring_sel) |=> !sel_ring);
  // R10: ring phase ends only on the synchronized count completion
  a_r10_handover_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_mode) |-> $past(settle_done));
  // R10: crystal select never rises straight out of the ring select
  a_r10_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_xtal) |-> $past(!sel_ring));
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import stopwake_pkg::*;
#(
  parameter int SETTLE_CYCLES = 65536,
  parameter int INT_SRC       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xtal_clk,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [WR_W-1:0]    reg_wdata,
  output logic [RD_W-1:0]    reg_rdata,
  input  logic               instr_done,
  input  logic               ext_irq,
  input  logic               ext_irq_en,
  input  logic               pf_irq,
  input  logic               pf_irq_en,
  input  logic               pf_rst,
  input  logic [INT_SRC-1:0] int_irq,
  output logic               stopped,
  output logic               core_clk_en,
  output logic               xtal_en,
  output logic               bandgap_en,
  output logic               sel_ring,
  output logic               sel_xtal
);
  localparam int SRC_W = INT_SRC + 2;

  logic stop_pend, bgs, rsel;
  logic in_run, stop_take, soft_clr, ring_mode, settle_req;
  logic done_x, settle_done;
  logic wake_irq, wake_rst;
  logic [SRC_W-1:0] src, allow;

  // Wake classes: internal sources are never allowed while clocks are off.
  assign src      = {pf_irq, ext_irq, int_irq};
  assign allow    = {bgs & pf_irq_en, ext_irq_en, {INT_SRC{1'b0}}};
  assign wake_irq = |(src & allow);
  assign wake_rst = bgs & pf_rst;

  assign bandgap_en = !stopped || bgs;

  sw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .in_run(in_run), .stop_take(stop_take),
    .soft_clr(soft_clr), .ring_mode(ring_mode), .stop_pend(stop_pend),
    .bgs(bgs), .rsel(rsel)
  );

  sw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_pend(stop_pend), .instr_done(instr_done),
    .settle_done(settle_done), .wake_irq(wake_irq), .wake_rst(wake_rst),
    .ring_sel(rsel), .stopped(stopped), .core_clk_en(core_clk_en),
    .xtal_en(xtal_en), .sel_ring(sel_ring), .sel_xtal(sel_xtal),
    .ring_mode(ring_mode), .in_run(in_run), .stop_take(stop_take),
    .soft_clr(soft_clr), .settle_req(settle_req)
  );

  sw_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .xtal_clk(xtal_clk), .rst_n(rst_n), .req(settle_req), .done(done_x)
  );

  sw_sync2 u_done_sync (.clk(clk), .rst_n(rst_n), .d(done_x), .q(settle_done));

  // R5: with no allowed wake present, stop persists whatever int_irq does
  a_r5_internal_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !(ext_irq && ext_irq_en) && !(bgs && (pf_rst || (pf_irq && pf_irq_en))))
    |=> stopped);
  // R11: a power-fail reset wake returns the control bits to defaults
  a_r11_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && bgs && pf_rst) |=> (!bgs && !rsel && !sel_ring));
  // R3: clocks remain off for the whole stop period
  a_r3_clocks_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && $past(stopped)) |-> (!xtal_en && !core_clk_en && !sel_xtal));
endmodule

// File: tb/stopwake_ctrl_bench.sv
`timescale 1ns/100ps
module stopwake_ctrl_bench;
  localparam int SETTLE = 16;
  localparam int CP     = 5;
  localparam int XP     = 7;
  localparam int LO     = SETTLE * XP / CP;
  localparam int HI     = (SETTLE + 4) * XP / CP + 8;

  logic       clk = 0, xtal_clk = 0, rst_n = 0;
  logic       reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [1:0] reg_wdata = 0;
  logic [2:0] reg_rdata;
  logic       instr_done = 0, ext_irq = 0, ext_irq_en = 0;
  logic       pf_irq = 0, pf_irq_en = 0, pf_rst = 0;
  logic [2:0] int_irq = 0;
  logic       stopped, core_clk_en, xtal_en, bandgap_en, sel_ring, sel_xtal;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  always #3.5 xtal_clk = ~xtal_clk;

  stopwake_ctrl #(.SETTLE_CYCLES(SETTLE), .INT_SRC(3)) u_stopwake_ctrl (
    .clk(clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .instr_done(instr_done), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
    .pf_irq(pf_irq), .pf_irq_en(pf_irq_en), .pf_rst(pf_rst), .int_irq(int_irq),
    .stopped(stopped), .core_clk_en(core_clk_en), .xtal_en(xtal_en),
    .bandgap_en(bandgap_en), .sel_ring(sel_ring), .sel_xtal(sel_xtal)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic enter_stop();
    wr(2'd0, 2'b10);
    instr_done = 1;
    tick();
    instr_done = 0;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CP * 150000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int v, n;
    bit wake, ring, rstw, seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 / R7: reset state
    chk(stopped == 0 && sel_xtal == 1 && core_clk_en == 1 && xtal_en == 1, "R1 reset outputs", stopped, 0);
    chk(bandgap_en == 1, "R7 run bandgap", bandgap_en, 1);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 reset read", v, 0);
    end
    // R1: field positions
    wr(2'd1, 2'b11); rd(2'd1, v); chk(v == 1, "R1 bandgap-keep bit0", v, 1);
    chk(bandgap_en == 1, "R7 run bandgap with keep", bandgap_en, 1);
    wr(2'd2, 2'b11); rd(2'd2, v); chk(v == 2, "R1 ring-select bit1", v, 2);
    wr(2'd0, 2'b10); rd(2'd0, v); chk(v == 2, "R1 stop bit1", v, 2);
    wr(2'd0, 2'b00); rd(2'd0, v); chk(v == 0, "R1 stop cleared", v, 0);
    wr(2'd3, 2'b11); rd(2'd3, v); chk(v == 0, "R1 addr3", v, 0);
    wr(2'd1, 2'b00); wr(2'd2, 2'b00);
    // R2: armed stop waits for instruction completion
    wr(2'd0, 2'b10);
    repeat (3) tick();
    chk(stopped == 0, "R2 no entry before instr_done", stopped, 0);
    instr_done = 1; tick(); instr_done = 0;
    chk(stopped == 1, "R2 entry", stopped, 1);
    rd(2'd0, v); chk(v == 0, "R2 stop bit consumed", v, 0);
    // R3 / R6
    chk(!xtal_en && !core_clk_en && !sel_ring && !sel_xtal, "R3 clocks off", xtal_en, 0);
    chk(bandgap_en == 0, "R6 bandgap off in stop", bandgap_en, 0);
    // R5: internal interrupts swept
    for (int k = 1; k < 8; k++) begin
      int_irq = 3'(k); tick(); int_irq = 0; tick();
      chk(stopped == 1, "R5 internal irq ignored", stopped, 1);
    end
    // R4: disabled external interrupt
    ext_irq = 1; tick(); tick(); ext_irq = 0;
    chk(stopped == 1, "R4 disabled ext ignored", stopped, 1);
    // R6: power-fail events without bandgap-keep
    pf_irq_en = 1; pf_irq = 1; pf_rst = 1; tick(); tick();
    pf_irq = 0; pf_irq_en = 0; pf_rst = 0;
    chk(stopped == 1, "R6 power-fail ignored", stopped, 1);
    // R4 / R8: enabled external wake on crystal path
    ext_irq_en = 1; ext_irq = 1; tick(); ext_irq = 0; ext_irq_en = 0;
    chk(stopped == 0 && xtal_en == 1 && core_clk_en == 0, "R4 R8 wake", core_clk_en, 0);
    n = 0; seen = 0;
    while (!sel_xtal && n < 200) begin tick(); n++; seen |= sel_ring; end
    chk(n >= LO && n <= HI, "R8 settle time", n, LO);
    chk(!seen, "R8 no ring phase", seen, 0);
    repeat (8) tick();

    // Sweep bandgap-keep x ring-select x wake source
    for (int b = 0; b < 2; b++)
      for (int g = 0; g < 2; g++)
        for (int s = 0; s < 3; s++) begin
          wr(2'd1, 2'(b)); wr(2'd2, 2'(g << 1));
          enter_stop();
          chk(stopped == 1, "R2 sweep entry", stopped, 1);
          chk(bandgap_en == b[0], "R6 bandgap in stop", bandgap_en, b);
          case (s)
            0: begin ext_irq_en = 1; ext_irq = 1; end
            1: begin pf_irq_en = 1; pf_irq = 1; end
            default: pf_rst = 1;
          endcase
          tick();
          ext_irq = 0; ext_irq_en = 0; pf_irq = 0; pf_irq_en = 0; pf_rst = 0;
          wake = (s == 0) || (b == 1);
          rstw = wake && (s == 2);
          ring = wake && (g == 1) && (s != 2);
          if (!wake) begin
            chk(stopped == 1, "R6 power-fail needs keep", stopped, 1);
            ext_irq_en = 1; ext_irq = 1; tick(); ext_irq = 0; ext_irq_en = 0;
            ring = (g == 1);
          end
          chk(stopped == 0, "R4 R6 woke", stopped, 0);
          chk(bandgap_en == 1, "R7 bandgap after wake", bandgap_en, 1);
          chk(sel_ring == ring && core_clk_en == ring, "R9 clock source", sel_ring, ring);
          if (rstw) begin
            rd(2'd1, v); chk(v == 0, "R11 keep cleared", v, 0);
            rd(2'd2, v); chk(v == 0, "R11 ring-select cleared", v, 0);
          end
          if (ring) begin
            rd(2'd2, v); chk(v == 6, "R9 ring-active set", v, 6);
            wr(2'd0, 2'b10);
            rd(2'd0, v); chk(v == 0, "R12 stop write in ring", v, 0);
            reg_addr = 2'd2; #1;
            n = 0;
            while (reg_rdata[2] && n < 200) begin tick(); n++; end
            chk(n >= LO - 2 && n <= HI, "R10 ring duration", n, LO);
            chk(!sel_ring && !sel_xtal, "R10 break cycle", sel_xtal, 0);
            tick();
            chk(sel_xtal && core_clk_en, "R10 crystal selected", sel_xtal, 1);
            instr_done = 1; tick(); instr_done = 0;
            chk(stopped == 0, "R12 no stop after handover", stopped, 0);
            rd(2'd0, v); chk(v == 0, "R12 stop bit clear", v, 0);
          end else begin
            n = 0; seen = 0;
            while (!sel_xtal && n < 200) begin tick(); n++; seen |= sel_ring; end
            chk(n >= LO && n <= HI, "R8 R11 settle time", n, LO);
            chk(!seen, "R8 R11 crystal path", seen, 0);
          end
          repeat (8) tick();
        end
    report();
  end
endmodule